// File: doc/BRIEF.md
# Multiplexed dot-matrix refresh controller

This block drives a row-multiplexed LED matrix of eight character cells. Each cell is 5 columns wide and 7 rows high. The block walks the seven rows from top to bottom, one fixed-length slot per row. For each row it asks an external glyph source for that row's dot data for all eight characters. It then drives one registered row strobe together with 40 registered column enables.

Three controls shape what is lit:
- A 3-bit level code sets how long the strobe and columns stay on inside every row slot. Seven steps give decreasing brightness and the eighth code blanks the display.
- A per-character flash mask hides chosen characters during the dark half of a slow 128-frame period, when flashing is enabled.
- A global blink hides every character during that same dark half, and takes precedence over the flash mask.

The level code and the control bits are copied into internal holding registers only when a frame wraps. A frame therefore never mixes two settings. Several units reset together stay in lock-step, because reset clears every counter.

Top module: `dot_scan_top`

## Requirements
- R1: While rst_ni is low, row_sel_o and col_en_o are all zero and glyph_row_o is 0. The holding registers reset to level code 7 with flash and blink off, so the first frame (224 clocks) after reset release is fully dark whatever the inputs are.
- R2: Rows are scanned 0 (top) to 6 (bottom). Each row slot lasts 32 clocks, so one frame lasts 224 clocks. glyph_row_o shows the row of the current slot and changes only at a slot boundary. At most one bit of row_sel_o is set, and bit r selects row r.
- R3: Within each row slot, strobe and columns are on for the first 2*U clocks of the slot and off for the rest. The level code sets U: code 0 gives U=15, code 1 gives 12, code 2 gives 8, code 3 gives 6, code 4 gives 4, code 5 gives 3, code 6 gives 2, and code 7 gives 0. Code 7 keeps every output low. Columns are never on without a row strobe.
- R4: Character c (0..7) owns col_en_o[5c+4:5c]. In that field, bit 4 is the leftmost column and bit 0 the rightmost. While lit, the field equals glyph_data_i[5c+4:5c] as supplied for the row on glyph_row_o.
- R5: With flash enabled, a character whose mask bit is 1 shows no columns during frames 64..127 of each 128-frame period (28,672 clocks). It shows normally during frames 0..63. Frame 0 is the first frame after reset.
- R6: With flash disabled, the flash mask has no effect on any output.
- R7: With blink enabled, all eight characters show no columns during frames 64..127 and show normally in frames 0..63, regardless of the flash mask and flash enable.
- R8: level_i, flash_en_i, blink_en_i and flash_mask_i are sampled only on the clock edge that ends a frame. A change in mid-frame has no effect until the next frame starts.
- R9: Outputs are registered. The values after clock edge n reflect the scan position held before that edge, and the glyph data presented during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_i | input | 3 | Brightness level code (7 = blank) |
| flash_en_i | input | 1 | Enables per-character flash |
| blink_en_i | input | 1 | Enables whole-display blink |
| flash_mask_i | input | 8 | One flash bit per character |
| glyph_row_o | output | 3 | Row index requested from the glyph source |
| glyph_data_i | input | 40 | Row dots for all characters, 5 bits per character |
| row_sel_o | output | 7 | Row strobes, one-hot or zero |
| col_en_o | output | 40 | Column enables, 5 per character |

## Verification
Every output is due exactly one clock after the scan position that produced it. A new setting first shows one clock after the edge that ends the frame in which it was applied. Flash and blink darkness starts one clock after the edge that enters frame 64. The bench keeps its own scan position, frame number and holding registers. On each rising edge it pushes the expected strobe, columns and requested row for the value registered by that edge. A monitor pops the item on the following falling edge, so it compares a settled result against the prediction for that same edge. The stimulus changes inputs in mid-frame and runs whole 128-frame periods, so both the frame-boundary sampling and the dark half are observed.

// File: rtl/dot_scan_pkg.sv
package dot_scan_pkg;

  localparam int LEVEL_W = 3;
  localparam int UNIT_W  = 4;

  // duty units per row slot for each level code; code 7 blanks
  function automatic logic [UNIT_W-1:0] level_units(input logic [LEVEL_W-1:0] code);
    logic [UNIT_W-1:0] u;
    case (code)
      3'd0:    u = 4'd15;
      3'd1:    u = 4'd12;
      3'd2:    u = 4'd8;
      3'd3:    u = 4'd6;
      3'd4:    u = 4'd4;
      3'd5:    u = 4'd3;
      3'd6:    u = 4'd2;
      default: u = 4'd0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/dot_scan_timer.sv
module dot_scan_timer #(
  parameter int SLOT_CLKS    = 32,
  parameter int NUM_ROWS     = 7,
  parameter int FLASH_FRAMES = 128,
  localparam int SW = $clog2(SLOT_CLKS),
  localparam int RW = $clog2(NUM_ROWS),
  localparam int FW = $clog2(FLASH_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] slot_o,
  output logic [RW-1:0] row_o,
  output logic [FW-1:0] frame_o,
  output logic          frame_end_o
);

  logic [SW-1:0] slot_q;
  logic [RW-1:0] row_q;
  logic [FW-1:0] frame_q;
  logic          slot_last, row_last, frame_last;

  assign slot_last   = (slot_q == SW'(SLOT_CLKS - 1));
  assign row_last    = (row_q == RW'(NUM_ROWS - 1));
  assign frame_last  = (frame_q == FW'(FLASH_FRAMES - 1));
  assign frame_end_o = slot_last && row_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      row_q   <= '0;
      frame_q <= '0;
    end else begin
      slot_q <= slot_last ? '0 : slot_q + 1'b1;
      if (slot_last) row_q <= row_last ? '0 : row_q + 1'b1;
      if (frame_end_o) frame_q <= frame_last ? '0 : frame_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign row_o   = row_q;
  assign frame_o = frame_q;

endmodule

// File: rtl/dot_scan_latch.sv
module dot_scan_latch #(
  parameter int NUM_CHARS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [2:0]           level_i,
  input  logic                 flash_en_i,
  input  logic                 blink_en_i,
  input  logic [NUM_CHARS-1:0] mask_i,
  output logic [2:0]           level_o,
  output logic                 flash_en_o,
  output logic                 blink_en_o,
  output logic [NUM_CHARS-1:0] mask_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o    <= 3'b111;
      flash_en_o <= 1'b0;
      blink_en_o <= 1'b0;
      mask_o     <= '0;
    end else if (load_i) begin
      level_o    <= level_i;
      flash_en_o <= flash_en_i;
      blink_en_o <= blink_en_i;
      mask_o     <= mask_i;
    end
  end

endmodule

// File: rtl/dot_scan_duty.sv
module dot_scan_duty
  import dot_scan_pkg::*;
#(
  parameter int SLOT_CLKS = 32,
  localparam int SW = $clog2(SLOT_CLKS),
  localparam int CLKS_PER_UNIT = SLOT_CLKS / 16
) (
  input  logic [SW-1:0]      slot_i,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               on_o
);

  logic [SW:0] limit;

  always_comb begin
    limit = (SW+1)'(level_units(level_i)) * (SW+1)'(CLKS_PER_UNIT);
    on_o  = ({1'b0, slot_i} < limit);
  end

endmodule

// File: rtl/dot_scan_pixels.sv
module dot_scan_pixels #(
  parameter int NUM_CHARS    = 8,
  parameter int NUM_ROWS     = 7,
  parameter int NUM_COLS     = 5,
  parameter int FLASH_FRAMES = 128,
  localparam int RW = $clog2(NUM_ROWS),
  localparam int FW = $clog2(FLASH_FRAMES),
  localparam int CW = NUM_CHARS * NUM_COLS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 on_i,
  input  logic [RW-1:0]        row_i,
  input  logic [FW-1:0]        frame_i,
  input  logic                 flash_en_i,
  input  logic                 blink_en_i,
  input  logic [NUM_CHARS-1:0] mask_i,
  input  logic [CW-1:0]        glyph_i,
  output logic [NUM_ROWS-1:0]  row_sel_o,
  output logic [CW-1:0]        col_en_o
);

  logic                dark;
  logic [NUM_ROWS-1:0] row_d;
  logic [CW-1:0]       col_d;

  // dark half of the flash period
  assign dark = (frame_i >= FW'(FLASH_FRAMES / 2));

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_d[r] = on_i && (row_i == RW'(r));
  end

  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
    logic hide;
    // blink wins over flash
    assign hide = blink_en_i ? dark : (flash_en_i && mask_i[c] && dark);
    assign col_d[c*NUM_COLS +: NUM_COLS] =
      (on_i && !hide) ? glyph_i[c*NUM_COLS +: NUM_COLS] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_sel_o <= '0;
      col_en_o  <= '0;
    end else begin
      row_sel_o <= row_d;
      col_en_o  <= col_d;
    end
  end

endmodule

// File: rtl/dot_scan_top.sv
module dot_scan_top #(
  parameter int NUM_CHARS    = 8,
  parameter int NUM_ROWS     = 7,
  parameter int NUM_COLS     = 5,
  parameter int SLOT_CLKS    = 32,
  parameter int FLASH_FRAMES = 128
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [2:0]                        level_i,
  input  logic                              flash_en_i,
  input  logic                              blink_en_i,
  input  logic [NUM_CHARS-1:0]              flash_mask_i,
  output logic [$clog2(NUM_ROWS)-1:0]       glyph_row_o,
  input  logic [NUM_CHARS*NUM_COLS-1:0]     glyph_data_i,
  output logic [NUM_ROWS-1:0]               row_sel_o,
  output logic [NUM_CHARS*NUM_COLS-1:0]     col_en_o
);

  localparam int SW = $clog2(SLOT_CLKS);
  localparam int RW = $clog2(NUM_ROWS);
  localparam int FW = $clog2(FLASH_FRAMES);

  logic [SW-1:0]        slot_q;
  logic [RW-1:0]        row_q;
  logic [FW-1:0]        frame_q;
  logic                 frame_end;
  logic [2:0]           level_q;
  logic                 flash_q, blink_q;
  logic [NUM_CHARS-1:0] mask_q;
  logic                 duty_on;

  dot_scan_timer #(
    .SLOT_CLKS   (SLOT_CLKS),
    .NUM_ROWS    (NUM_ROWS),
    .FLASH_FRAMES(FLASH_FRAMES)
  ) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_o     (slot_q),
    .row_o      (row_q),
    .frame_o    (frame_q),
    .frame_end_o(frame_end)
  );

  dot_scan_latch #(.NUM_CHARS(NUM_CHARS)) latch_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (frame_end),
    .level_i   (level_i),
    .flash_en_i(flash_en_i),
    .blink_en_i(blink_en_i),
    .mask_i    (flash_mask_i),
    .level_o   (level_q),
    .flash_en_o(flash_q),
    .blink_en_o(blink_q),
    .mask_o    (mask_q)
  );

  dot_scan_duty #(.SLOT_CLKS(SLOT_CLKS)) duty_i (
    .slot_i (slot_q),
    .level_i(level_q),
    .on_o   (duty_on)
  );

  dot_scan_pixels #(
    .NUM_CHARS   (NUM_CHARS),
    .NUM_ROWS    (NUM_ROWS),
    .NUM_COLS    (NUM_COLS),
    .FLASH_FRAMES(FLASH_FRAMES)
  ) pixels_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_i      (duty_on),
    .row_i     (row_q),
    .frame_i   (frame_q),
    .flash_en_i(flash_q),
    .blink_en_i(blink_q),
    .mask_i    (mask_q),
    .glyph_i   (glyph_data_i),
    .row_sel_o (row_sel_o),
    .col_en_o  (col_en_o)
  );

  assign glyph_row_o = row_q;

endmodule

// File: rtl/dot_scan_chk.sv
module dot_scan_chk #(
  parameter int NUM_ROWS     = 7,
  parameter int CW           = 40,
  parameter int SLOT_CLKS    = 32,
  parameter int FLASH_FRAMES = 128,
  localparam int SW = $clog2(SLOT_CLKS),
  localparam int RW = $clog2(NUM_ROWS),
  localparam int FW = $clog2(FLASH_FRAMES)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [SW-1:0]       slot_i,
  input logic [FW-1:0]       frame_i,
  input logic                frame_end_i,
  input logic [2:0]          level_q_i,
  input logic                blink_q_i,
  input logic [RW-1:0]       glyph_row_i,
  input logic [NUM_ROWS-1:0] row_sel_i,
  input logic [CW-1:0]       col_en_i
);

  // R2
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_i));

  // R2
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i != SW'(SLOT_CLKS - 1)) |=> $stable(glyph_row_i));

  // R3
  col_needs_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_en_i != '0) |-> (row_sel_i != '0));

  // R3
  blank_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q_i == 3'b111) |=> (row_sel_i == '0));

  // R7
  blink_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_q_i && (frame_i >= FW'(FLASH_FRAMES / 2))) |=> (col_en_i == '0));

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(level_q_i));

endmodule

bind dot_scan_top dot_scan_chk #(
  .NUM_ROWS    (NUM_ROWS),
  .CW          (NUM_CHARS * NUM_COLS),
  .SLOT_CLKS   (SLOT_CLKS),
  .FLASH_FRAMES(FLASH_FRAMES)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slot_i     (slot_q),
  .frame_i    (frame_q),
  .frame_end_i(frame_end),
  .level_q_i  (level_q),
  .blink_q_i  (blink_q),
  .glyph_row_i(glyph_row_o),
  .row_sel_i  (row_sel_o),
  .col_en_i   (col_en_o)
);

// File: tb/dot_scan_top_tb_top.sv
`timescale 1ns/1ps
module dot_scan_top_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  level_i = 3'd0;
  logic        flash_en_i = 1'b0;
  logic        blink_en_i = 1'b0;
  logic [7:0]  flash_mask_i = 8'h00;
  logic [2:0]  glyph_row_o;
  logic [39:0] glyph_data_i;
  logic [6:0]  row_sel_o;
  logic [39:0] col_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  typedef struct {
    logic [6:0]  rs;
    logic [39:0] ce;
    logic [2:0]  gr;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  dot_scan_top dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level_i),
    .flash_en_i  (flash_en_i),
    .blink_en_i  (blink_en_i),
    .flash_mask_i(flash_mask_i),
    .glyph_row_o (glyph_row_o),
    .glyph_data_i(glyph_data_i),
    .row_sel_o   (row_sel_o),
    .col_en_o    (col_en_o)
  );

  function automatic logic [4:0] pat(input int r, input int c);
    return 5'(((r * 11) + (c * 7) + 3) ^ (c << 1));
  endfunction

  // R4: glyph source, char c in bits [5c+4:5c]
  always_comb begin
    for (int c = 0; c < 8; c++) glyph_data_i[c*5 +: 5] = pat(int'(glyph_row_o), c);
  end

  // R3 on-clock counts per level code
  function automatic int on_clks(input logic [2:0] lv);
    case (lv)
      3'd0: return 30;
      3'd1: return 24;
      3'd2: return 16;
      3'd3: return 12;
      3'd4: return 8;
      3'd5: return 6;
      3'd6: return 4;
      default: return 0;
    endcase
  endfunction

  // reference model driven from the requirements
  int         m_pos, m_frame;
  logic [2:0] m_lvl;
  bit         m_fen, m_bl;
  logic [7:0] m_mask;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pos = 0; m_frame = 0; m_lvl = 3'b111; m_fen = 0; m_bl = 0; m_mask = 0;
      sb_q.delete();
    end else begin
      item_t it;
      int  slot, row;
      bit  on, dark, hide;
      slot = m_pos % 32;
      row  = m_pos / 32;
      on   = slot < on_clks(m_lvl);
      dark = m_frame >= 64;
      it.rs = on ? 7'(1 << row) : 7'd0;
      for (int c = 0; c < 8; c++) begin
        hide = m_bl ? dark : (m_fen && m_mask[c] && dark);
        it.ce[c*5 +: 5] = (on && !hide) ? pat(row, c) : 5'd0;
      end
      it.tag = cur_tag;
      if (m_pos == 223) begin
        m_lvl = level_i; m_fen = flash_en_i; m_bl = blink_en_i; m_mask = flash_mask_i;
        m_frame = (m_frame + 1) % 128;
      end
      m_pos = (m_pos + 1) % 224;
      it.gr = 3'(m_pos / 32);
      sb_q.push_back(it);
    end
  end

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (row_sel_o !== it.rs) begin
        errors++;
        $display("FAIL %s row_sel actual %b expected %b", it.tag, row_sel_o, it.rs);
      end
      checks++;
      if (col_en_o !== it.ce) begin
        errors++;
        $display("FAIL %s col_en actual %h expected %h", it.tag, col_en_o, it.ce);
      end
      checks++;
      if (glyph_row_o !== it.gr) begin
        errors++;
        $display("FAIL R2 glyph_row actual %0d expected %0d", glyph_row_o, it.gr);
      end
    end
  end

  task automatic check_reset();
    checks++;
    if (row_sel_o !== 7'd0 || col_en_o !== 40'd0 || glyph_row_o !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b/%h/%0d expected 0/0/0",
               row_sel_o, col_en_o, glyph_row_o);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    run(3);
    check_reset();
    rst_ni = 1'b1;
    cur_tag = "R1";   // first frame dark
    run(224);
    cur_tag = "R9";
    run(224);
    cur_tag = "R2";
    run(224);
    cur_tag = "R4";
    run(224);
    cur_tag = "R3";
    for (int lv = 0; lv < 8; lv++) begin
      level_i = 3'(lv);
      run(2 * 224);
    end
    cur_tag = "R8";   // mid-frame changes
    run(100);
    level_i = 3'd2;
    run(60);
    level_i = 3'd5;
    run(224);
    level_i = 3'd0;
    run(300);
    cur_tag = "R5";
    flash_en_i = 1'b1; flash_mask_i = 8'hA5;
    run(130 * 224);
    cur_tag = "R6";
    flash_en_i = 1'b0; flash_mask_i = 8'hFF;
    run(130 * 224);
    cur_tag = "R7";
    blink_en_i = 1'b1; flash_en_i = 1'b1; flash_mask_i = 8'h0F;
    run(130 * 224);
    rst_ni = 1'b0;
    run(2);
    check_reset();
    rst_ni = 1'b1;
    cur_tag = "R1";
    run(300);
    run(1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule